// File: doc/BRIEF.md
# Host Firmware Address Remap Window

This block sits between a host-side firmware bus decoder and a local system bus master. It holds one programmable window that moves host firmware-space addresses into local address space. A request carries a 32-bit host address and a valid strobe. One clock later the block returns either a hit flag with the translated local address, or a miss flag with an all-zero address.

The translation works only on the upper half-word of the address. A replace mask selects which upper bits come from the local target base. A keep mask selects which upper bits pass through from the request. The lower half-word always passes through unchanged. As a result, window sizes and offsets come in 64 KiB steps. Two independent cycle-enable bits gate every hit.

The register file is a small synchronous port with four 32-bit words. It also holds a forwarding-mode bit beside a set of sticky status bits. Each status bit is set by a one-cycle pulse on an input and cleared when software writes a 1 to it.

Top module: `fw_remap_window`

## Requirements
- R1: After reset every register reads zero, `fwd_mode` is 0, `xl_valid`/`xl_hit`/`xl_miss` are 0 and `xl_addr` is zero; the first request after reset misses.
- R2: A read issued with `reg_req`=1, `reg_we`=0 presents the register value on `reg_rdata` after the next rising edge. The words at byte offsets 0x88 (window bases) and 0x8C (masks) store all 32 bits. The word at 0x80 keeps only bits 8 and 10 and reads 0 in every other bit. Any other offset reads zero.
- R3: A request hits only when `req_addr[31:16]` and the host window base (0x88 bits [15:0]) agree in every bit position where the replace mask (0x8C bits [31:16]) is 1.
- R4: On a hit, `xl_addr[31:16]` = (`req_addr[31:16]` AND keep mask, 0x8C bits [15:0]) OR (target base, 0x88 bits [31:16], AND replace mask).
- R5: On a hit, `xl_addr[15:0]` equals `req_addr[15:0]`.
- R6: A request can hit only when both 0x80 bit 8 (host-to-local enable) and 0x80 bit 10 (firmware-cycle enable) are 1; if either is 0, the request misses.
- R7: On a miss, `xl_miss`=1, `xl_hit`=0 and `xl_addr`=0.
- R8: Results appear exactly one cycle after the `req_valid` edge, with `xl_valid`=1 in that cycle. When no request was presented, `xl_valid`, `xl_hit` and `xl_miss` are 0.
- R9: Bit 17 of 0x84 is a plain read/write forwarding-mode bit, driven out on `fwd_mode`.
- R10: All bits of 0x84 except bit 17 are status bits. A 1 on `stat_set[i]` sets bit i. Writing 1 to bit i clears it. Writing 0 leaves it unchanged.
- R11: When a set pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R12: `stat_set[17]` has no effect; the mode bit changes only through register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| stat_set | input | 32 | One-cycle pulses that set status bits |
| fwd_mode | output | 1 | Forwarding-mode bit |
| req_valid | input | 1 | Host request strobe |
| req_addr | input | 32 | Host firmware-space address |
| xl_valid | output | 1 | Result valid |
| xl_hit | output | 1 | Request fell inside the enabled window |
| xl_miss | output | 1 | Request missed or the window was disabled |
| xl_addr | output | 32 | Translated local address, zero on a miss |

## Verification
The bench programs power-of-two windows from 64 KiB to 8 MiB, plus raw random mask pairs. It probes the first and last address of each window and the addresses just outside it. A design that compares the wrong half of 0x88, or that applies the keep mask to the match, would hit outside the window or miss at its edges.

Each enable bit is cleared on its own. A design that ORs the enables instead of ANDing them would keep hitting.

The status tests cover three cases: a write-1 to one bit with other status bits set, a set pulse and a clear in the same cycle, and a pulse on the mode-bit position. A design that clears with plain write data would wipe neighbouring bits. One that gives priority to the clear would lose the simultaneous event. One that lets the set input reach bit 17 would flip `fwd_mode`.

// File: rtl/remap_pkg.sv
package remap_pkg;
   localparam int REG_W      = 32;
   localparam int HALF_W     = REG_W / 2;
   localparam int OFS_W      = 8;

   // Register byte offsets (fixed by the software programming sequence)
   localparam logic [OFS_W-1:0] OFS_CTRL = 8'h80;
   localparam logic [OFS_W-1:0] OFS_MODE = 8'h84;
   localparam logic [OFS_W-1:0] OFS_BASE = 8'h88;
   localparam logic [OFS_W-1:0] OFS_MASK = 8'h8C;

   // Bit positions software relies on
   localparam int BIT_EN_L2H = 8;
   localparam int BIT_EN_FW  = 10;
   localparam int BIT_FWD    = 17;

   localparam logic [REG_W-1:0] CTRL_KEEP = (REG_W'(1) << BIT_EN_L2H) |
                                            (REG_W'(1) << BIT_EN_FW);
   localparam logic [REG_W-1:0] STAT_MASK = ~(REG_W'(1) << BIT_FWD);

   typedef struct packed {
      logic              en_l2h;
      logic              en_fw;
      logic [HALF_W-1:0] tgt_base;
      logic [HALF_W-1:0] host_base;
      logic [HALF_W-1:0] repl_mask;
      logic [HALF_W-1:0] keep_mask;
   } win_cfg_t;
endpackage

// File: rtl/remap_regfile.sv
module remap_regfile
   import remap_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_req,
   input  logic             reg_we,
   input  logic [OFS_W-1:0] reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [REG_W-1:0] stat_set,
   output win_cfg_t         cfg,
   output logic             fwd_mode
);
   logic [REG_W-1:0] ctrl_q, base_q, mask_q, stat_q;
   logic             mode_q;
   logic             wr_ctrl, wr_mode, wr_base, wr_mask, rd_en;
   logic [REG_W-1:0] clr_bits, set_bits, rd_val;

   assign wr_ctrl = reg_req && reg_we && (reg_addr == OFS_CTRL);
   assign wr_mode = reg_req && reg_we && (reg_addr == OFS_MODE);
   assign wr_base = reg_req && reg_we && (reg_addr == OFS_BASE);
   assign wr_mask = reg_req && reg_we && (reg_addr == OFS_MASK);
   assign rd_en   = reg_req && !reg_we;

   assign clr_bits = wr_mode ? (reg_wdata & STAT_MASK) : '0;
   assign set_bits = stat_set & STAT_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         base_q <= '0;
         mask_q <= '0;
         stat_q <= '0;
         mode_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_KEEP;
         if (wr_base) base_q <= reg_wdata;
         if (wr_mask) mask_q <= reg_wdata;
         if (wr_mode) mode_q <= reg_wdata[BIT_FWD];
         stat_q <= (stat_q & ~clr_bits) | set_bits;
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_CTRL: rd_val = ctrl_q;
         OFS_MODE: rd_val = stat_q | (REG_W'(mode_q) << BIT_FWD);
         OFS_BASE: rd_val = base_q;
         OFS_MASK: rd_val = mask_q;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     reg_rdata <= '0;
      else if (rd_en) reg_rdata <= rd_val;
   end

   assign cfg.en_l2h    = ctrl_q[BIT_EN_L2H];
   assign cfg.en_fw     = ctrl_q[BIT_EN_FW];
   assign cfg.tgt_base  = base_q[REG_W-1:HALF_W];
   assign cfg.host_base = base_q[HALF_W-1:0];
   assign cfg.repl_mask = mask_q[REG_W-1:HALF_W];
   assign cfg.keep_mask = mask_q[HALF_W-1:0];
   assign fwd_mode      = mode_q;

   // R10: a write with no status bits set and no pulse leaves status intact
   assert_w1c_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && ((reg_wdata & STAT_MASK) == '0) && ((stat_set & STAT_MASK) == '0))
      |=> $stable(stat_q));
   // R11: a pulsed bit is set in the next cycle regardless of a clear
   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_set & STAT_MASK) != '0)
      |=> ((stat_q & $past(stat_set & STAT_MASK)) == $past(stat_set & STAT_MASK)));
   // R9 / R12: the mode bit follows register writes only
   assert_mode_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mode |=> (fwd_mode == $past(reg_wdata[BIT_FWD])));
   assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mode |=> $stable(fwd_mode));
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
   import remap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  win_cfg_t          cfg,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              xl_valid,
   output logic              xl_hit,
   output logic              xl_miss,
   output logic [ADDR_W-1:0] xl_addr
);
   localparam int LO_W = ADDR_W - HALF_W;

   logic [HALF_W-1:0] req_hi, new_hi, diff;
   logic [LO_W-1:0]   req_lo;
   logic              enabled, in_win, hit_c;

   assign req_hi = req_addr[ADDR_W-1:LO_W];
   assign req_lo = req_addr[LO_W-1:0];

   for (genvar b = 0; b < HALF_W; b++) begin : g_bit
      assign diff[b]   = cfg.repl_mask[b] & (req_hi[b] ^ cfg.host_base[b]);
      assign new_hi[b] = (req_hi[b] & cfg.keep_mask[b]) |
                         (cfg.tgt_base[b] & cfg.repl_mask[b]);
   end

   assign enabled = cfg.en_l2h & cfg.en_fw;
   assign in_win  = (diff == '0);
   assign hit_c   = enabled & in_win;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xl_valid <= 1'b0;
         xl_hit   <= 1'b0;
         xl_miss  <= 1'b0;
         xl_addr  <= '0;
      end else begin
         xl_valid <= req_valid;
         xl_hit   <= req_valid & hit_c;
         xl_miss  <= req_valid & ~hit_c;
         xl_addr  <= (req_valid & hit_c) ? {new_hi, req_lo} : '0;
      end
   end

   // R8: flags appear only with a result, exactly one of them
   assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |-> (xl_hit ^ xl_miss));
   assert_flags_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_valid |-> (!xl_hit && !xl_miss));
   // R7: a miss carries no address
   assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xl_miss |-> (xl_addr == '0));
   // R5: low half-word passes through
   assert_low_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit_c) |=> (xl_addr[LO_W-1:0] == $past(req_lo)));
   // R6: a disabled window never hits
   assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(cfg.en_l2h && cfg.en_fw)) |=> xl_miss);
endmodule

// File: rtl/fw_remap_window.sv
module fw_remap_window
   import remap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [31:0]       stat_set,
   output logic              fwd_mode,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              xl_valid,
   output logic              xl_hit,
   output logic              xl_miss,
   output logic [ADDR_W-1:0] xl_addr
);
   if (ADDR_W != REG_W) begin : g_bad_width
      $error("fw_remap_window: ADDR_W must equal the register width");
   end
   if (BIT_FWD >= REG_W || BIT_EN_FW >= REG_W) begin : g_bad_bits
      $error("fw_remap_window: control bit outside register");
   end

   win_cfg_t cfg;

   remap_regfile u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_req   (reg_req),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .stat_set  (stat_set),
      .cfg       (cfg),
      .fwd_mode  (fwd_mode)
   );

   remap_xlate #(.ADDR_W(ADDR_W)) u_xlate (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .xl_valid  (xl_valid),
      .xl_hit    (xl_hit),
      .xl_miss   (xl_miss),
      .xl_addr   (xl_addr)
   );
endmodule

// File: tb/test_fw_remap_window.sv
`timescale 1ns/1ps
module test_fw_remap_window;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_req, reg_we;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata, stat_set;
   logic        fwd_mode;
   logic        req_valid;
   logic [31:0] req_addr;
   logic        xl_valid, xl_hit, xl_miss;
   logic [31:0] xl_addr;

   int n_chk = 0;
   int n_fail = 0;

   // model of the programmed configuration
   logic [31:0] m_ctrl, m_base, m_mask;

   always #4 clk = ~clk;

   fw_remap_window i_fw_remap_window (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .stat_set(stat_set), .fwd_mode(fwd_mode), .req_valid(req_valid),
      .req_addr(req_addr), .xl_valid(xl_valid), .xl_hit(xl_hit),
      .xl_miss(xl_miss), .xl_addr(xl_addr));

   function automatic bit exp_hit(input logic [31:0] a);
      logic [15:0] rm;
      rm = m_mask[31:16];
      return m_ctrl[8] && m_ctrl[10] && ((a[31:16] & rm) == (m_base[15:0] & rm));
   endfunction

   function automatic logic [31:0] exp_addr(input logic [31:0] a);
      if (!exp_hit(a)) return 32'h0;
      return {(a[31:16] & m_mask[15:0]) | (m_base[31:16] & m_mask[31:16]), a[15:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_req = 0; reg_we = 0;
      if (a == 8'h80) m_ctrl = d & 32'h0000_0500;
      if (a == 8'h88) m_base = d;
      if (a == 8'h8C) m_mask = d;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_req = 1; reg_we = 0; reg_addr = a;
      @(negedge clk);
      reg_req = 0;
      d = reg_rdata;
   endtask

   // one request, result checked one cycle later (R8)
   task automatic probe(input string req, input logic [31:0] a);
      bit h;
      @(negedge clk);
      req_valid = 1; req_addr = a;
      @(negedge clk);
      req_valid = 0;
      h = exp_hit(a);
      check({req, " R8 valid"}, {31'd0, xl_valid}, 32'd1);
      check({req, " hit"}, {30'd0, xl_hit, xl_miss}, {30'd0, h, !h});
      check({req, " addr"}, xl_addr, exp_addr(a));
   endtask

   task automatic program_win(input int k, input logic [31:0] host, input logic [31:0] tgt);
      logic [31:0] sz;
      sz = 32'h1 << (16 + k);
      host = host & ~(sz - 1);
      tgt  = tgt & ~(sz - 1);
      reg_write(8'h88, {tgt[31:16], host[31:16]});
      reg_write(8'h8C, ~(sz - 1) | ((sz >> 16) - 1));
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] d, sz, hb, a;
      void'($urandom(32'd20240611));
      m_ctrl = 0; m_base = 0; m_mask = 0;
      rst_n = 0; reg_req = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
      stat_set = 0; req_valid = 0; req_addr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      check("R1 xl_valid", {31'd0, xl_valid}, 32'd0);
      check("R1 xl_addr", xl_addr, 32'd0);
      check("R1 fwd_mode", {31'd0, fwd_mode}, 32'd0);
      foreach (d[i]) ;
      for (int o = 0; o < 4; o++) begin
         reg_read(8'h80 + 8'(o * 4), d);
         check("R1 reg zero", d, 32'd0);
      end
      probe("R1 first request misses", 32'h1234_5678);

      // R2: register storage
      reg_write(8'h88, 32'hDEAD_BEEF);
      reg_read(8'h88, d); check("R2 base word", d, 32'hDEAD_BEEF);
      reg_write(8'h8C, 32'hA5A5_5A5A);
      reg_read(8'h8C, d); check("R2 mask word", d, 32'hA5A5_5A5A);
      reg_write(8'h80, 32'hFFFF_FFFF);
      reg_read(8'h80, d); check("R2 ctrl keeps bits 8,10", d, 32'h0000_0500);
      reg_read(8'h40, d); check("R2 unmapped offset", d, 32'd0);

      // R3/R4/R5: power-of-two windows, enables on
      for (int w = 0; w < 24; w++) begin
         int k;
         k = w % 8;
         program_win(k, $urandom, $urandom);
         sz = 32'h1 << (16 + k);
         hb = {m_base[15:0], 16'h0};
         probe("R3 first address", hb);
         probe("R3 last address", hb + sz - 1);
         probe("R4 inside", hb + ($urandom & (sz - 1)));
         probe("R3 just past end", hb + sz);
         probe("R3 just below start", hb - 1);
         a = $urandom;
         probe("R5 random", a);
      end

      // R4: raw random masks
      for (int w = 0; w < 20; w++) begin
         reg_write(8'h88, $urandom);
         reg_write(8'h8C, $urandom);
         probe("R4 raw match", {m_base[15:0], 16'($urandom)} ^ {16'($urandom) & ~m_mask[31:16], 16'h0});
         probe("R4 raw any", $urandom);
      end

      // R6: enable gating
      program_win(3, 32'h4000_0000, 32'h8000_0000);
      reg_write(8'h80, 32'h0000_0100);
      probe("R6 only l2h enabled", 32'h4001_2345);
      reg_write(8'h80, 32'h0000_0400);
      probe("R6 only fw enabled", 32'h4001_2345);
      reg_write(8'h80, 32'h0000_0500);
      probe("R6 both enabled", 32'h4001_2345);
      check("R6 model sanity hit", {31'd0, exp_hit(32'h4001_2345)}, 32'd1);
      // R7: miss output
      probe("R7 outside miss", 32'h4100_0000);

      // R8: no request -> idle flags
      @(negedge clk); @(negedge clk);
      check("R8 idle", {29'd0, xl_valid, xl_hit, xl_miss}, 32'd0);

      // R9: mode bit
      reg_write(8'h84, 32'h0002_0000);
      check("R9 fwd_mode set", {31'd0, fwd_mode}, 32'd1);
      reg_read(8'h84, d); check("R9 mode readback", d, 32'h0002_0000);

      // R10: set pulses then write-1 clear one bit
      @(negedge clk); stat_set = 32'h8000_0013; @(negedge clk); stat_set = 0;
      reg_read(8'h84, d); check("R10 status set", d, 32'h8002_0013);
      reg_write(8'h84, 32'h0002_0002);
      reg_read(8'h84, d); check("R10 w1c keeps others", d, 32'h8002_0011);
      reg_write(8'h84, 32'h0002_0000);
      reg_read(8'h84, d); check("R10 write 0 no effect", d, 32'h8002_0011);

      // R11: set and clear together
      @(negedge clk);
      stat_set = 32'h0000_0001; reg_req = 1; reg_we = 1; reg_addr = 8'h84;
      reg_wdata = 32'h8002_0001;
      @(negedge clk);
      stat_set = 0; reg_req = 0; reg_we = 0;
      reg_read(8'h84, d); check("R11 set wins", d, 32'h0002_0011);

      // R12: pulse on the mode position ignored
      reg_write(8'h84, 32'h0000_0011);
      check("R12 mode cleared", {31'd0, fwd_mode}, 32'd0);
      @(negedge clk); stat_set = 32'h0002_0000; @(negedge clk); stat_set = 0;
      check("R12 fwd_mode unaffected", {31'd0, fwd_mode}, 32'd0);
      reg_read(8'h84, d); check("R12 reg unaffected", d, 32'd0);

      finish_run();
   end
endmodule